// File: doc/BRIEF.md
# Partitioned SIMD Multiply-Accumulate Unit

A pipelined arithmetic unit on a 32-bit word that can be cut into independent lanes: 8-bit, 16-bit or 32-bit. Each 16-bit half of the word picks its own split, so one word may carry two byte lanes next to a 16-bit lane. A single merge bit turns the whole word into one 32-bit lane. Per lane, the unit multiplies, adds, multiply-accumulates into a lane-wide accumulator slice, or counts leading zeros. Software uses the leading-zero count to normalise mantissas when it emulates floating point.

A wide mode treats the two operands as unsigned 32-bit values. It adds their full 64-bit product into a 64-bit accumulator and returns both halves of the sum. Every operation enters with a valid strobe. Its result leaves exactly three cycles later, paired with a valid flag. Operations are issued back to back with no stalls.

Top module: `simd_mac`

## Requirements
- R1: `part_i[1:0]` sets the split of bits 15:0 and `part_i[3:2]` the split of bits 31:16. In each field, 00 gives two 8-bit lanes and any other value gives one 16-bit lane. When `part_i[4]` is 1 the word is one 32-bit lane and the two fields are ignored.
- R2: Opcode 0 (multiply) returns in each lane the low lane-width bits of the unsigned product of the lane's operand fields. No bit crosses into a neighbouring lane.
- R3: Opcode 1 (add) returns in each lane the sum of the operand fields modulo 2^lane-width. No carry crosses a lane boundary.
- R4: Opcode 2 (lane MAC) adds each lane's unsigned product to the matching slice of accumulator bits 31:0, wrapping modulo the lane width. It returns the new bits 31:0 on `res_o` and leaves accumulator bits 63:32 unchanged.
- R5: Opcode 3 (clear) sets all 64 accumulator bits to zero and returns zero on both result ports.
- R6: Opcode 4 (leading-zero count) returns in each lane the number of leading zeros of operand `a_i`'s field, right-aligned in the lane. An all-zero field returns the lane width.
- R7: Opcode 5 (wide MAC) adds the full 64-bit product of `a_i` and `b_i`, both taken unsigned, to the 64-bit accumulator modulo 2^64. It returns bits 31:0 of the new value on `res_o` and bits 63:32 on `res_hi_o`, whatever `part_i` holds.
- R8: `valid_o` is high exactly in the third cycle after a cycle with `valid_i` high. `res_hi_o` is zero for every opcode except 5. Opcodes 6 and 7 return zero and leave the accumulator unchanged.
- R9: Cycles with `valid_i` low change neither the accumulator nor the stream of later results.
- R10: After reset, `valid_o`, `res_o`, `res_hi_o` and the accumulator are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| part_i | input | 5 | Lane partition: two half fields and a merge bit |
| a_i | input | 32 | Operand A |
| b_i | input | 32 | Operand B |
| valid_o | output | 1 | Result valid, three cycles after the strobe |
| res_o | output | 32 | Result word / accumulator bits 31:0 |
| res_hi_o | output | 32 | Accumulator bits 63:32 for wide MAC, else zero |

## Verification
A corrupted accumulator slice does not show at the ports right away. It appears on the first lane MAC or wide MAC that reads it, three cycles after that operation is issued. The bench therefore follows idle gaps, clears and partition changes with MACs whose `b_i` is zero, which read the accumulator back unchanged. A carry that leaks across a lane boundary, or a wrong lane split, is wrong in the very result word of the operation that caused it. The bench therefore compares every valid output against a lane-by-lane model, including all-ones operands that force carries at each boundary.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;
  localparam int DW = 32;
  localparam int AW = 2 * DW;
  localparam int PW = 5;
  localparam int HW = DW / 2;

  localparam logic [2:0] OP_MUL   = 3'd0;
  localparam logic [2:0] OP_ADD   = 3'd1;
  localparam logic [2:0] OP_MAC   = 3'd2;
  localparam logic [2:0] OP_CLR   = 3'd3;
  localparam logic [2:0] OP_LZC   = 3'd4;
  localparam logic [2:0] OP_MAC64 = 3'd5;

  // pick per half the vector computed at the width that half is split into
  function automatic logic [DW-1:0] sel_lanes(input logic [DW-1:0] v8,
                                               input logic [DW-1:0] v16,
                                               input logic [DW-1:0] v32,
                                               input logic [PW-1:0] part);
    logic [DW-1:0] r;
    for (int h = 0; h < 2; h++) begin
      if (part[4])                 r[HW*h +: HW] = v32[HW*h +: HW];
      else if (part[2*h +: 2] != 2'b00) r[HW*h +: HW] = v16[HW*h +: HW];
      else                         r[HW*h +: HW] = v8[HW*h +: HW];
    end
    return r;
  endfunction
endpackage

// File: rtl/simd_width_alu.sv
module simd_width_alu #(
  parameter int DW = simd_mac_pkg::DW,
  parameter int LW = 8
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] mul_o,
  output logic [DW-1:0] add_o,
  output logic [DW-1:0] lzc_o
);
  localparam int NL = DW / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LW-1:0] a_l, b_l;
    int lz;
    assign a_l = a_i[l*LW +: LW];
    assign b_l = b_i[l*LW +: LW];
    assign mul_o[l*LW +: LW] = a_l * b_l;
    assign add_o[l*LW +: LW] = a_l + b_l;
    always_comb begin
      lz = LW;
      for (int k = 0; k < LW; k++)
        if (a_l[k]) lz = LW - 1 - k;
    end
    assign lzc_o[l*LW +: LW] = LW'(lz);
  end
endmodule

// File: rtl/simd_width_add.sv
module simd_width_add #(
  parameter int DW = simd_mac_pkg::DW,
  parameter int LW = 8
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  output logic [DW-1:0] sum_o
);
  localparam int NL = DW / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign sum_o[l*LW +: LW] = x_i[l*LW +: LW] + y_i[l*LW +: LW];
  end
endmodule

// File: rtl/simd_mac.sv
module simd_mac
  import simd_mac_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [2:0]    op_i,
  input  logic [PW-1:0] part_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          valid_o,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] res_hi_o
);
  localparam int NW = 3;

  // stage 1: operand capture
  logic          v1;
  logic [2:0]    op1;
  logic [PW-1:0] part1;
  logic [DW-1:0] a1, b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1 <= 1'b0; op1 <= '0; part1 <= '0; a1 <= '0; b1 <= '0;
    end else begin
      v1 <= valid_i;
      if (valid_i) begin
        op1 <= op_i; part1 <= part_i; a1 <= a_i; b1 <= b_i;
      end
    end
  end

  // stage 2: lane arithmetic at every width, then select
  logic [DW-1:0] mul_w [NW];
  logic [DW-1:0] add_w [NW];
  logic [DW-1:0] lzc_w [NW];
  logic [DW-1:0] sum_w [NW];
  logic [DW-1:0] mul_s, add_s, lzc_s, r_d;
  logic [AW-1:0] p64_d;

  logic          v2;
  logic [2:0]    op2;
  logic [PW-1:0] part2;
  logic [DW-1:0] r2;
  logic [AW-1:0] p64_2;
  logic [AW-1:0] acc_q;

  for (genvar g = 0; g < NW; g++) begin : g_w
    simd_width_alu #(.DW(DW), .LW(8 << g)) u_alu (
      .a_i(a1), .b_i(b1), .mul_o(mul_w[g]), .add_o(add_w[g]), .lzc_o(lzc_w[g])
    );
    simd_width_add #(.DW(DW), .LW(8 << g)) u_acc_add (
      .x_i(acc_q[DW-1:0]), .y_i(r2), .sum_o(sum_w[g])
    );
  end

  assign mul_s = sel_lanes(mul_w[0], mul_w[1], mul_w[2], part1);
  assign add_s = sel_lanes(add_w[0], add_w[1], add_w[2], part1);
  assign lzc_s = sel_lanes(lzc_w[0], lzc_w[1], lzc_w[2], part1);
  assign p64_d = {{DW{1'b0}}, a1} * {{DW{1'b0}}, b1};

  always_comb begin
    unique case (op1)
      OP_MUL, OP_MAC: r_d = mul_s;
      OP_ADD:         r_d = add_s;
      OP_LZC:         r_d = lzc_s;
      default:        r_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v2 <= 1'b0; op2 <= '0; part2 <= '0; r2 <= '0; p64_2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        op2 <= op1; part2 <= part1; r2 <= r_d; p64_2 <= p64_d;
      end
    end
  end

  // stage 3: accumulate and drive outputs
  logic [DW-1:0] mac_s;
  logic [AW-1:0] acc64_s;

  assign mac_s   = sel_lanes(sum_w[0], sum_w[1], sum_w[2], part2);
  assign acc64_s = acc_q + p64_2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0; res_o <= '0; res_hi_o <= '0; acc_q <= '0;
    end else begin
      valid_o <= v2;
      if (v2) begin
        res_hi_o <= '0;
        unique case (op2)
          OP_MAC: begin
            acc_q[DW-1:0] <= mac_s;
            res_o         <= mac_s;
          end
          OP_CLR: begin
            acc_q <= '0;
            res_o <= '0;
          end
          OP_MAC64: begin
            acc_q    <= acc64_s;
            res_o    <= acc64_s[DW-1:0];
            res_hi_o <= acc64_s[AW-1:DW];
          end
          default: res_o <= r2;
        endcase
      end
    end
  end
endmodule

// File: rtl/simd_mac_chk.sv
module simd_mac_chk
  import simd_mac_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [2:0]    op_i,
  input logic [PW-1:0] part_i,
  input logic          valid_o,
  input logic [DW-1:0] res_o,
  input logic [DW-1:0] res_hi_o,
  input logic [AW-1:0] acc_q
);
  logic [2:0]    vh;
  logic [2:0]    oph [3];
  logic          mh [3];
  logic [1:0]    cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vh <= '0; cnt <= '0;
      for (int i = 0; i < 3; i++) begin oph[i] <= '0; mh[i] <= 1'b0; end
    end else begin
      vh <= {vh[1:0], valid_i};
      oph[0] <= op_i; oph[1] <= oph[0]; oph[2] <= oph[1];
      mh[0] <= part_i[4]; mh[1] <= mh[0]; mh[2] <= mh[1];
      if (cnt != 2'd3) cnt <= cnt + 2'd1;
    end
  end

  // R8
  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == 2'd3 |-> valid_o == vh[2]);

  // R8
  a_r8_hi_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3 && valid_o && oph[2] != OP_MAC64) |-> res_hi_o == '0);

  // R5
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3 && valid_o && oph[2] == OP_CLR) |-> (res_o == '0 && acc_q == '0));

  // R6
  a_r6_lzc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == 2'd3 && valid_o && oph[2] == OP_LZC && mh[2]) |-> res_o <= DW);

  // R9
  a_r9_idle_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != 2'd0 && !valid_o) |-> $stable(acc_q));
endmodule

bind simd_mac simd_mac_chk u_chk (.*);

// File: tb/simd_mac_tb.sv
module simd_mac_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [4:0]  part_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [31:0] res_o, res_hi_o;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  simd_mac u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .part_i(part_i),
    .a_i(a_i), .b_i(b_i), .valid_o(valid_o), .res_o(res_o), .res_hi_o(res_hi_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  bit [63:0] m_acc;
  bit        pv [3];
  bit [31:0] pr [3];
  bit [31:0] ph [3];
  bit [2:0]  pop [3];
  bit [4:0]  ppart [3];

  function automatic int lane_w(bit [4:0] part, int pos);
    if (part[4]) return 32;
    return (part[2*(pos/16) +: 2] != 2'b00) ? 16 : 8;
  endfunction

  function automatic bit [31:0] lanes(int op, bit [31:0] a, bit [31:0] b,
                                      bit [31:0] acc, bit [4:0] part);
    bit [63:0] m, x, y, z, v, r;
    int pos, w;
    r = 0; pos = 0;
    while (pos < 32) begin
      w = lane_w(part, pos);
      m = (64'h1 << w) - 1;
      x = (64'(a) >> pos) & m;
      y = (64'(b) >> pos) & m;
      z = (64'(acc) >> pos) & m;
      v = 0;
      case (op)
        0: v = (x * y) & m;
        1: v = (x + y) & m;
        2: v = (z + x * y) & m;
        4: begin
          v = 64'(w);
          for (int k = 0; k < w; k++) if (x[k]) v = 64'(w - 1 - k);
        end
        default: v = 0;
      endcase
      r = r | (v << pos);
      pos += w;
    end
    return r[31:0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0;
      for (int i = 0; i < 3; i++) begin
        pv[i] = 0; pr[i] = 0; ph[i] = 0; pop[i] = 0; ppart[i] = 0;
      end
    end else begin
      bit [31:0] r, h;
      for (int i = 2; i > 0; i--) begin
        pv[i] = pv[i-1]; pr[i] = pr[i-1]; ph[i] = ph[i-1];
        pop[i] = pop[i-1]; ppart[i] = ppart[i-1];
      end
      r = 0; h = 0;
      if (valid_i) begin
        case (op_i)
          3'd2: begin
            r = lanes(2, a_i, b_i, m_acc[31:0], part_i);
            m_acc[31:0] = r;
          end
          3'd3: m_acc = 0;
          3'd5: begin
            m_acc = m_acc + 64'(a_i) * 64'(b_i);
            r = m_acc[31:0]; h = m_acc[63:32];
          end
          3'd0, 3'd1, 3'd4: r = lanes(int'(op_i), a_i, b_i, 32'h0, part_i);
          default: r = 0;
        endcase
      end
      pv[0] = valid_i; pr[0] = r; ph[0] = h; pop[0] = op_i; ppart[0] = part_i;
    end
  end

  function automatic string tag_of(bit [2:0] op);
    case (op)
      3'd0: return "R2/R1";
      3'd1: return "R3/R1";
      3'd2: return "R4/R9";
      3'd3: return "R5";
      3'd4: return "R6/R1";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (valid_o !== pv[2]) begin
        failures++;
        $display("FAIL R8 valid_o got %0b exp %0b", valid_o, pv[2]);
      end else if (pv[2]) begin
        checks++;
        if (res_o !== pr[2] || res_hi_o !== ph[2]) begin
          failures++;
          $display("FAIL %s op=%0d part=%05b got %h_%h exp %h_%h", tag_of(pop[2]),
                   pop[2], ppart[2], res_hi_o, res_o, ph[2], pr[2]);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYC && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic issue(bit v, bit [2:0] op, bit [4:0] part, bit [31:0] a, bit [31:0] b);
    @(negedge clk);
    valid_i = v; op_i = op; part_i = part; a_i = a; b_i = b;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) issue(0, 3'd0, 5'd0, 32'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0 || res_hi_o !== '0) begin
      failures++;
      $display("FAIL R10 reset got v=%0b %h_%h exp 0 0_0", valid_o, res_hi_o, res_o);
    end
    @(negedge clk); rst_n = 1'b1;
    // R10: accumulator is zero, read back with b=0
    issue(1, 3'd2, 5'b00000, 32'hFFFFFFFF, 32'h0);
    issue(1, 3'd5, 5'b00000, 32'h0, 32'h0);
    idle(4);

    // R2 with R1 modes: all-ones forces every lane boundary
    for (int p = 0; p < 32; p++) issue(1, 3'd0, 5'(p), 32'hFFFFFFFF, 32'hFFFFFFFF);
    issue(1, 3'd0, 5'b00001, 32'h1234_8081, 32'h0302_7F02);
    // R3: carries must stop at lane edges
    for (int p = 0; p < 32; p++) issue(1, 3'd1, 5'(p), 32'hFFFFFFFF, 32'h00010101);
    issue(1, 3'd1, 5'b10000, 32'hFFFFFFFF, 32'h1);
    // R4: lane accumulation wraps, mixed partitions
    issue(1, 3'd3, 5'b0, 32'h0, 32'h0);
    for (int i = 0; i < 6; i++) issue(1, 3'd2, 5'b00100, 32'hF0F0_7F80, 32'h0303_0303);
    issue(1, 3'd2, 5'b10000, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    // R9: idle gap, then read back unchanged
    idle(5);
    issue(1, 3'd2, 5'b00000, 32'h5555_5555, 32'h0);
    // R5 clear then readback
    issue(1, 3'd3, 5'b11111, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(1, 3'd2, 5'b10000, 32'hAAAA_AAAA, 32'h0);
    // R6 leading zeros, including all-zero lanes
    for (int p = 0; p < 32; p++) issue(1, 3'd4, 5'(p), 32'h0001_0080, 32'h0);
    issue(1, 3'd4, 5'b10000, 32'h0, 32'h0);
    issue(1, 3'd4, 5'b00000, 32'h8040_0100, 32'h0);
    // R7 wide accumulate with carry into upper half and wrap
    issue(1, 3'd3, 5'b0, 32'h0, 32'h0);
    for (int i = 0; i < 5; i++) issue(1, 3'd5, 5'b00101, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(1, 3'd2, 5'b00000, 32'h0101_0101, 32'h0101_0101);
    issue(1, 3'd5, 5'b0, 32'h0, 32'h0);
    // R8 unused opcodes
    issue(1, 3'd6, 5'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    issue(1, 3'd7, 5'b10000, 32'h1234_5678, 32'h9ABC_DEF0);
    issue(1, 3'd5, 5'b0, 32'h0, 32'h0);
    idle(3);

    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit [31:0] a, b;
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 7) == 0) a = 32'h0;
      if ($urandom_range(0, 7) == 0) b = 32'hFFFF_FFFF;
      issue($urandom_range(0, 3) != 0, 3'($urandom_range(0, 7)), 5'($urandom),
            a, (i % 13 == 0) ? 32'h0 : b);
    end
    idle(6);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule